// File: doc/BRIEF.md
# Timer-Compare CSR Access Gate

This block rules on every access to the four timer-compare CSR addresses: the supervisor compare register (low half 0x14D, high half 0x15D) and the virtual-supervisor compare register (low half 0x24D, high half 0x25D). The hart presents the address together with its privilege context:

- the current privilege level and the virtualization flag;
- whether the hart runs with 32-bit registers;
- the timer bit of the machine and hypervisor counter-enable registers;
- the timer-compare enable bit of the machine and hypervisor environment-config registers.

A registered verdict comes back. The verdict is one of three: allow, illegal-instruction exception, or virtual-instruction exception. When the access is allowed, the block also reports whether it lands on the virtual-supervisor register.

A guest running virtualized in supervisor mode that names the supervisor address is steered to the virtual-supervisor register without being told. The CSR data path and the delivery of exceptions belong to the pipeline around the block.

The machine-level checks are illegal-instruction checks, and they are tested before any hypervisor-level check. A virtual-instruction exception therefore appears only once the machine layer has granted access. Verdicts appear a fixed number of register stages after the request (`OUT_STAGES`, default 1).

Top module: `tcmp_access_gate`

## Requirements
- R1: Only addresses 0x14D, 0x15D, 0x24D and 0x25D set `rsp_hit`. For any other address `rsp_hit` is 0, the verdict is allow (code 0) and `rsp_to_virt` is 0.
- R2: A high-half address (0x15D or 0x25D) with `mode_rv32`=0 gives illegal (code 1) in every privilege mode, and this check takes precedence over all others.
- R3: Machine mode (`req_priv`=3) is allowed on every covered address that R2 does not reject. `rsp_to_virt` is 1 exactly when the address is 0x24D or 0x25D.
- R4: User mode (`req_priv`=0) and the reserved level 2 give illegal on every covered address, whatever `req_virt` is.
- R5: Supervisor mode (`req_priv`=1) with `m_stce`=0 gives illegal.
- R6: Supervisor mode with `m_tm`=0 gives illegal.
- R7: Non-virtualized supervisor mode (`req_virt`=0) that passes R5 and R6 is allowed. `rsp_to_virt` is 1 exactly for addresses 0x24D and 0x25D.
- R8: Virtualized supervisor mode that is allowed on address 0x14D or 0x15D is redirected, so `rsp_to_virt` is 1.
- R9: Virtualized supervisor mode that passes the machine checks but has `h_tm`=0 gives virtual-instruction (code 2).
- R10: Virtualized supervisor mode that passes the machine checks but has `h_stce`=0 gives virtual-instruction.
- R11: Virtualized supervisor mode that names 0x24D or 0x25D directly, and passes the machine checks, gives virtual-instruction.
- R12: When a machine-level check and a hypervisor-level check both fail, the verdict is illegal, not virtual-instruction.
- R13: `rsp_valid` repeats `req_valid` `OUT_STAGES` cycles later. A synchronous active-high `rst` clears `rsp_valid` and the verdict fields to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W | CSR address of the access |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Hart is virtualized |
| mode_rv32 | input | 1 | Hart runs with 32-bit registers |
| m_tm | input | 1 | Timer bit of machine counter-enable |
| h_tm | input | 1 | Timer bit of hypervisor counter-enable |
| m_stce | input | 1 | Timer-compare enable in machine env config |
| h_stce | input | 1 | Timer-compare enable in hypervisor env config |
| rsp_valid | output | 1 | Verdict present |
| rsp_hit | output | 1 | Address is one of the four covered addresses |
| rsp_verdict | output | 2 | 0 allow, 1 illegal instruction, 2 virtual instruction |
| rsp_to_virt | output | 1 | Allowed access targets the virtual-supervisor register |

## Verification
Every verdict field is a pure function of the inputs presented with `req_valid`. It is due exactly `OUT_STAGES` rising edges later, which is one edge with the defaults.

The bench drives each request just after a falling edge and waits for the next rising edge. It samples at the falling edge that follows, once the output register has settled and before the next request is applied.

It sweeps every covered address, two uncovered ones, all four privilege codes, both virtualization states, both register widths and all sixteen enable-bit combinations. Idle cycles between sweeps confirm that `rsp_valid` drops one cycle after `req_valid` does.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_R = 2'd2,
    PRV_M = 2'd3
  } prv_e;

  typedef enum logic [1:0] {
    VD_ALLOW   = 2'd0,
    VD_ILLEGAL = 2'd1,
    VD_VIRTUAL = 2'd2
  } verdict_e;

  typedef struct packed {
    logic     hit;
    verdict_e verdict;
    logic     to_virt;
  } decision_t;

  localparam decision_t DECISION_IDLE = '{hit: 1'b0, verdict: VD_ALLOW, to_virt: 1'b0};

endpackage

// File: rtl/tcmp_addr_decode.sv
module tcmp_addr_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SUP_LO_ADDR = 12'h14D,
  parameter logic [ADDR_W-1:0] SUP_HI_ADDR = 12'h15D,
  parameter logic [ADDR_W-1:0] VSP_LO_ADDR = 12'h24D,
  parameter logic [ADDR_W-1:0] VSP_HI_ADDR = 12'h25D
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_hi,
  output logic              is_vsp
);

  localparam int N_ADDR = 4;
  // index bit 0: high half, index bit 1: virtual-supervisor register
  localparam logic [ADDR_W-1:0] ADDR_TAB [N_ADDR] =
    '{SUP_LO_ADDR, SUP_HI_ADDR, VSP_LO_ADDR, VSP_HI_ADDR};

  logic [N_ADDR-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < N_ADDR; gi++) begin : g_match
      assign match[gi] = (addr == ADDR_TAB[gi]);
    end
  endgenerate

  always_comb begin
    hit    = |match;
    is_hi  = match[1] | match[3];
    is_vsp = match[2] | match[3];
  end

  always_comb begin
    if (addr == addr) begin
      assert ($onehot0(match))
        else $error("p_addr_unique_r1: address matched more than one entry");
    end
  end

endmodule

// File: rtl/tcmp_rule_eval.sv
module tcmp_rule_eval
  import tcmp_pkg::*;
(
  input  logic      hit,
  input  logic      is_hi,
  input  logic      is_vsp,
  input  logic [1:0] priv,
  input  logic      virt,
  input  logic      rv32,
  input  logic      m_tm,
  input  logic      h_tm,
  input  logic      m_stce,
  input  logic      h_stce,
  output decision_t dec
);

  logic width_bad;
  logic mach_bad;
  logic hyp_bad;
  logic is_mach;
  logic is_sup;

  always_comb begin
    is_mach   = (priv == PRV_M);
    is_sup    = (priv == PRV_S);
    width_bad = is_hi & ~rv32;
    // machine-layer refusal for a supervisor access
    mach_bad  = ~m_stce | ~m_tm;
    // hypervisor-layer refusal for a virtualized supervisor access
    hyp_bad   = is_vsp | ~h_stce | ~h_tm;
  end

  always_comb begin
    dec = DECISION_IDLE;
    if (hit) begin
      dec.hit = 1'b1;
      if (width_bad) begin
        dec.verdict = VD_ILLEGAL;
      end else if (is_mach) begin
        dec.verdict = VD_ALLOW;
        dec.to_virt = is_vsp;
      end else if (!is_sup) begin
        dec.verdict = VD_ILLEGAL;
      end else if (mach_bad) begin
        dec.verdict = VD_ILLEGAL;
      end else if (!virt) begin
        dec.verdict = VD_ALLOW;
        dec.to_virt = is_vsp;
      end else if (hyp_bad) begin
        dec.verdict = VD_VIRTUAL;
      end else begin
        dec.verdict = VD_ALLOW;
        dec.to_virt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcmp_access_gate.sv
module tcmp_access_gate
  import tcmp_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int OUT_STAGES = 1,
  parameter logic [ADDR_W-1:0] SUP_LO_ADDR = 12'h14D,
  parameter logic [ADDR_W-1:0] SUP_HI_ADDR = 12'h15D,
  parameter logic [ADDR_W-1:0] VSP_LO_ADDR = 12'h24D,
  parameter logic [ADDR_W-1:0] VSP_HI_ADDR = 12'h25D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic              mode_rv32,
  input  logic              m_tm,
  input  logic              h_tm,
  input  logic              m_stce,
  input  logic              h_stce,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_verdict,
  output logic              rsp_to_virt
);

  localparam int LAST = OUT_STAGES - 1;

  logic      dec_hit;
  logic      dec_hi;
  logic      dec_vsp;
  decision_t dec_now;

  tcmp_addr_decode #(
    .ADDR_W      (ADDR_W),
    .SUP_LO_ADDR (SUP_LO_ADDR),
    .SUP_HI_ADDR (SUP_HI_ADDR),
    .VSP_LO_ADDR (VSP_LO_ADDR),
    .VSP_HI_ADDR (VSP_HI_ADDR)
  ) u_decode (
    .addr   (req_addr),
    .hit    (dec_hit),
    .is_hi  (dec_hi),
    .is_vsp (dec_vsp)
  );

  tcmp_rule_eval u_rules (
    .hit    (dec_hit),
    .is_hi  (dec_hi),
    .is_vsp (dec_vsp),
    .priv   (req_priv),
    .virt   (req_virt),
    .rv32   (mode_rv32),
    .m_tm   (m_tm),
    .h_tm   (h_tm),
    .m_stce (m_stce),
    .h_stce (h_stce),
    .dec    (dec_now)
  );

  logic      vld_q [OUT_STAGES];
  decision_t dec_q [OUT_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
      dec_q[0] <= DECISION_IDLE;
    end else begin
      vld_q[0] <= req_valid;
      dec_q[0] <= req_valid ? dec_now : DECISION_IDLE;
    end
  end

  genvar gs;
  generate
    for (gs = 1; gs < OUT_STAGES; gs++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[gs] <= 1'b0;
          dec_q[gs] <= DECISION_IDLE;
        end else begin
          vld_q[gs] <= vld_q[gs-1];
          dec_q[gs] <= dec_q[gs-1];
        end
      end
    end
  endgenerate

  always_comb begin
    rsp_valid   = vld_q[LAST];
    rsp_hit     = dec_q[LAST].hit;
    rsp_verdict = dec_q[LAST].verdict;
    rsp_to_virt = dec_q[LAST].to_virt;
  end

  // Stage-0 checks against the request of the previous cycle
  p_valid_follow_r13: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_q[0] == $past(req_valid)));

  p_hi64_illegal_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hi && !mode_rv32))
      |-> (dec_q[0].verdict == VD_ILLEGAL));

  p_mach_allow_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hit && req_priv == 2'd3 && (mode_rv32 || !dec_hi)))
      |-> (dec_q[0].verdict == VD_ALLOW));

  p_user_illegal_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hit && req_priv == 2'd0))
      |-> (dec_q[0].verdict == VD_ILLEGAL));

  p_menv_illegal_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hit && req_priv == 2'd1 && !m_stce))
      |-> (dec_q[0].verdict == VD_ILLEGAL));

  p_mtm_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hit && req_priv == 2'd1 && !m_tm))
      |-> (dec_q[0].verdict == VD_ILLEGAL));

  p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && dec_hit && req_priv == 2'd1 && req_virt)
      && dec_q[0].verdict == VD_ALLOW) |-> dec_q[0].to_virt);

  p_miss_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !dec_hit))
      |-> (!dec_q[0].hit && dec_q[0].verdict == VD_ALLOW && !dec_q[0].to_virt));

  p_virt_needs_sup_r12: assert property (@(posedge clk) disable iff (rst)
    (dec_q[0].verdict == VD_VIRTUAL) |-> (!$past(rst) && $past(req_priv == 2'd1 && req_virt && m_stce && m_tm)));

endmodule

// File: tb/tcmp_access_gate_bench.sv
module tcmp_access_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_priv;
  logic              req_virt;
  logic              mode_rv32;
  logic              m_tm, h_tm, m_stce, h_stce;
  logic              rsp_valid, rsp_hit, rsp_to_virt;
  logic [1:0]        rsp_verdict;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcmp_access_gate u_tcmp_access_gate (
    .clk, .rst, .req_valid, .req_addr, .req_priv, .req_virt, .mode_rv32,
    .m_tm, .h_tm, .m_stce, .h_stce,
    .rsp_valid, .rsp_hit, .rsp_verdict, .rsp_to_virt
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (addr=%h priv=%0d virt=%0d rv32=%0d mtm=%0d htm=%0d mstce=%0d hstce=%0d)",
               tag, what, act, exp, req_addr, req_priv, req_virt, mode_rv32, m_tm, h_tm, m_stce, h_stce);
    end
  endtask

  // Reference model written from the requirement list
  task automatic expect_of(input logic [11:0] a, input int p, input bit v, input bit w32,
                           input bit mtm, input bit htm, input bit mst, input bit hst,
                           output int hit, output int vd, output int tv, output string tag);
    bit hi, vs, in;
    in = (a == 12'h14D) || (a == 12'h15D) || (a == 12'h24D) || (a == 12'h25D);
    hi = (a == 12'h15D) || (a == 12'h25D);
    vs = (a == 12'h24D) || (a == 12'h25D);
    hit = in; vd = 0; tv = 0;
    if (!in)                 begin tag = "R1"; end
    else if (hi && !w32)     begin tag = "R2"; vd = 1; end
    else if (p == 3)         begin tag = "R3"; tv = vs; end
    else if (p != 1)         begin tag = "R4"; vd = 1; end
    else if (!mst || !mtm) begin
      vd = 1;
      if (v && (vs || !htm || !hst)) tag = "R12";
      else tag = !mst ? "R5" : "R6";
    end
    else if (!v)             begin tag = "R7"; tv = vs; end
    else if (vs)             begin tag = "R11"; vd = 2; end
    else if (!hst)           begin tag = "R10"; vd = 2; end
    else if (!htm)           begin tag = "R9"; vd = 2; end
    else                     begin tag = "R8"; tv = 1; end
  endtask

  initial begin
    logic [11:0] addrs [6];
    addrs[0] = 12'h14D; addrs[1] = 12'h15D; addrs[2] = 12'h24D;
    addrs[3] = 12'h25D; addrs[4] = 12'h14C; addrs[5] = 12'h34D;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_priv = 2'd0; req_virt = 1'b0;
    mode_rv32 = 1'b0; m_tm = 1'b0; h_tm = 1'b0; m_stce = 1'b0; h_stce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state
    check("R13", rsp_valid, 0, "reset rsp_valid");
    check("R13", rsp_verdict, 0, "reset verdict");
    check("R13", rsp_hit, 0, "reset hit");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R13", rsp_valid, 0, "idle rsp_valid");

    for (int w = 0; w < 2; w++) begin
      for (int ai = 0; ai < 6; ai++) begin
        for (int p = 0; p < 4; p++) begin
          for (int v = 0; v < 2; v++) begin
            for (int b = 0; b < 16; b++) begin
              int eh, ev, et;
              string tg;
              req_valid = 1'b1;
              req_addr  = addrs[ai];
              req_priv  = p[1:0];
              req_virt  = v[0];
              mode_rv32 = w[0];
              m_tm = b[0]; h_tm = b[1]; m_stce = b[2]; h_stce = b[3];
              expect_of(addrs[ai], p, v[0], w[0], b[0], b[1], b[2], b[3], eh, ev, et, tg);
              @(posedge clk); @(negedge clk);
              check("R13", rsp_valid, 1, "rsp_valid");
              check(tg, rsp_hit, eh, "hit");
              check(tg, rsp_verdict, ev, "verdict");
              check(tg, rsp_to_virt, et, "to_virt");
            end
          end
        end
      end
      req_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R13", rsp_valid, 0, "rsp_valid after idle");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule